// File: doc/BRIEF.md
# Sign-Magnitude Signed Multiplier

This block multiplies two small signed integers that arrive in two's complement. Inside, each operand is first recoded into a sign bit and a magnitude. An unsigned core multiplies the two magnitudes, and a separate XOR forms the sign of the product. The result is then recoded into an 8-bit two's-complement product. Values near zero have few set bits in sign-magnitude form, so the inner datapath toggles far less than a two's-complement array does when operands cluster around zero.

A build-time parameter selects one of two encoder variants:
- **Extend:** the magnitude field grows by one bit, so every input, including the most negative code, is kept exactly.
- **Clip:** the most negative input is saturated to the next value up, so the magnitude fits in three bits and the core is smaller.

A second parameter inserts an output register that captures the product when the valid input is high. The same register delays the valid flag by one cycle.

Top module: `smul_top`

## Requirements
- R1: In extend mode, the signed value of `prod_out` equals the exact product of the signed 4-bit operands `a_in` and `b_in`, for every one of the 256 operand pairs.
- R2: In extend mode, an operand of 4'b1000 (-8) is encoded with magnitude 8 and is not altered. For example, -8 times 1 gives 8'hF8 (-8).
- R3: In clip mode, an operand of -8 is used as -7. For every operand pair, the output equals the product of the operands after this substitution.
- R4: If either operand is zero, `prod_out` is exactly 8'h00. No negative zero is ever produced.
- R5: For a non-zero product, bit 7 of `prod_out` is the XOR of bit 3 of `a_in` and bit 3 of `b_in`.
- R6: With the output register enabled, `prod_out` and `out_valid` change one clock after the inputs are presented. `out_valid` follows `in_valid` with a one-cycle delay. While `in_valid` is low, `prod_out` holds its previous value.
- R7: While the synchronous active-high `rst` is high, `prod_out` is 0 and `out_valid` is 0 at each clock.
- R8: The extreme pairs give exact results in extend mode: -8 times -8 is +64 and -8 times 7 is -56. In clip mode the same pairs give +49 and -49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_in | input | 4 | First operand, two's complement |
| b_in | input | 4 | Second operand, two's complement |
| prod_out | output | 8 | Product, two's complement |
| out_valid | output | 1 | Product is valid |

## Verification
The bench goes after three groups of corner cases:
- **The -8 code.** Two ports share the same operands: one in extend mode, one in clip mode. An encoder that drops the extra magnitude bit would return 0 for -8 times 1. A missing clip stage would return 64 instead of 49 for -8 times -8.
- **Zero operands with negative partners.** A sign path that does not force zero would output 8'h80 or 8'h00 with a stray sign, instead of a clean zero.
- **Valid handling.** Presenting new operands with the valid input low exposes a register that loads every cycle. Checks immediately after reset expose a register that does not clear.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic {
        ENC_EXTEND = 1'b0,
        ENC_CLIP   = 1'b1
    } enc_mode_e;

    // Width of the magnitude field produced by the input encoder
    function automatic int mag_width(int op_w, enc_mode_e mode);
        return (mode == ENC_CLIP) ? op_w - 1 : op_w;
    endfunction

    // Largest magnitude the encoder may emit
    function automatic int mag_limit(int op_w, enc_mode_e mode);
        return (mode == ENC_CLIP) ? (1 << (op_w - 1)) - 1 : (1 << (op_w - 1));
    endfunction

endpackage

// File: rtl/smul_tc2sm.sv
module smul_tc2sm
    import smul_pkg::*;
#(
    parameter int        OP_W  = 4,
    parameter enc_mode_e MODE  = ENC_EXTEND,
    localparam int       MAG_W = mag_width(OP_W, MODE)
) (
    input  logic [OP_W-1:0]  tc_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o
);

    logic [OP_W-1:0] abs_full;

    always_comb begin
        abs_full = tc_i[OP_W-1] ? (~tc_i + 1'b1) : tc_i;
        sign_o   = tc_i[OP_W-1];
    end

    generate
        if (MODE == ENC_CLIP) begin : g_clip
            // Only the most negative code has the top bit of its magnitude set
            always_comb begin
                mag_o = abs_full[OP_W-1] ? {MAG_W{1'b1}} : abs_full[MAG_W-1:0];
            end

            always_comb begin
                AST_CLIP_RANGE: assert (32'(mag_o) <= 32'(mag_limit(OP_W, MODE))) else $error("clip range"); // R3
                if (tc_i == {1'b1, {(OP_W-1){1'b0}}})
                    AST_CLIP_MIN: assert (mag_o == {MAG_W{1'b1}}) else $error("clip min"); // R3
            end
        end else begin : g_extend
            logic signed [OP_W:0] rebuilt;

            always_comb begin
                mag_o = abs_full;
            end

            always_comb begin
                rebuilt = sign_o ? -$signed({1'b0, mag_o}) : $signed({1'b0, mag_o});
                AST_ENC_EXACT: assert (rebuilt == $signed({tc_i[OP_W-1], tc_i})) else $error("encode"); // R2
            end
        end
    endgenerate

endmodule

// File: rtl/smul_smcore.sv
module smul_smcore #(
    parameter int  MAG_W = 4,
    localparam int P_W   = 2 * MAG_W
) (
    input  logic             sa_i,
    input  logic [MAG_W-1:0] ma_i,
    input  logic             sb_i,
    input  logic [MAG_W-1:0] mb_i,
    output logic             sp_o,
    output logic [P_W-1:0]   mp_o
);

    logic both_nonzero;

    always_comb begin
        both_nonzero = (|ma_i) & (|mb_i);
        mp_o         = P_W'(ma_i) * P_W'(mb_i);
        sp_o         = (sa_i ^ sb_i) & both_nonzero;
    end

    always_comb begin
        AST_ZERO_MAG: assert ((mp_o == '0) == ((ma_i == '0) || (mb_i == '0))) else $error("zero mag"); // R4
        if (mp_o == '0)
            AST_NO_NEG_ZERO: assert (!sp_o) else $error("negative zero"); // R4
    end

endmodule

// File: rtl/smul_sm2tc.sv
module smul_sm2tc #(
    parameter int MAG_W = 8,
    parameter int OUT_W = 8
) (
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [OUT_W-1:0] tc_o
);

    logic [OUT_W-1:0] ext;

    always_comb begin
        ext  = OUT_W'(mag_i);
        tc_o = sign_i ? (~ext + 1'b1) : ext;
    end

    always_comb begin
        if (mag_i != '0)
            AST_SIGN_OUT: assert (tc_o[OUT_W-1] == sign_i) else $error("sign out"); // R5
        else
            AST_ZERO_OUT: assert (tc_o == '0) else $error("zero out"); // R4
    end

endmodule

// File: rtl/smul_top.sv
module smul_top
    import smul_pkg::*;
#(
    parameter int        OP_W    = 4,
    parameter enc_mode_e MODE    = ENC_EXTEND,
    parameter bit        OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     a_in,
    input  logic [OP_W-1:0]     b_in,
    output logic [2*OP_W-1:0]   prod_out,
    output logic                out_valid
);

    localparam int MAG_W  = mag_width(OP_W, MODE);
    localparam int PMAG_W = 2 * MAG_W;
    localparam int PROD_W = 2 * OP_W;

    logic              sa, sb, sp;
    logic [MAG_W-1:0]  ma, mb;
    logic [PMAG_W-1:0] mp;
    logic [PROD_W-1:0] prod_c;

    smul_tc2sm #(.OP_W(OP_W), .MODE(MODE)) enc_a_i (
        .tc_i  (a_in),
        .sign_o(sa),
        .mag_o (ma)
    );

    smul_tc2sm #(.OP_W(OP_W), .MODE(MODE)) enc_b_i (
        .tc_i  (b_in),
        .sign_o(sb),
        .mag_o (mb)
    );

    smul_smcore #(.MAG_W(MAG_W)) core_i (
        .sa_i(sa),
        .ma_i(ma),
        .sb_i(sb),
        .mb_i(mb),
        .sp_o(sp),
        .mp_o(mp)
    );

    smul_sm2tc #(.MAG_W(PMAG_W), .OUT_W(PROD_W)) dec_i (
        .sign_i(sp),
        .mag_i (mp),
        .tc_o  (prod_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    prod_out  <= '0;
                    out_valid <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid)
                        prod_out <= prod_c;
                end
            end

            AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid) else $error("valid lat"); // R6
            AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid) else $error("valid idle"); // R6
            AST_HOLD: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(prod_out)) else $error("hold"); // R6

            if (MODE == ENC_EXTEND) begin : g_exact
                logic signed [PROD_W-1:0] a_sx, b_sx, exact_c;
                always_comb begin
                    a_sx    = PROD_W'($signed(a_in));
                    b_sx    = PROD_W'($signed(b_in));
                    exact_c = a_sx * b_sx;
                end
                AST_EXACT: assert property (@(posedge clk) disable iff (rst)
                    in_valid |=> (prod_out == $past(exact_c))) else $error("exact"); // R1
            end
        end else begin : g_comb
            always_comb begin
                prod_out  = prod_c;
                out_valid = in_valid;
            end
        end
    endgenerate

endmodule

// File: tb/smul_top_tb_top.sv
`timescale 1ns/1ps
module smul_top_tb_top;
    import smul_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic [7:0] prod_ext, prod_clp;
    logic       vld_ext, vld_clp;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    smul_top #(.OP_W(4), .MODE(ENC_EXTEND), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
        .prod_out(prod_ext), .out_valid(vld_ext)
    );

    smul_top #(.OP_W(4), .MODE(ENC_CLIP), .OUT_REG(1'b1)) dut_clip_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
        .prod_out(prod_clp), .out_valid(vld_clp)
    );

    function automatic int sx4(int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic int ref_prod(int a, int b, bit clip);
        int sa = sx4(a);
        int sb = sx4(b);
        if (clip && sa == -8) sa = -7;
        if (clip && sb == -8) sb = -7;
        return sa * sb;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sval(logic [7:0] p);
        return int'($signed(p));
    endfunction

    task automatic apply(int a, int b, bit v);
        @(negedge clk);
        a_in     = 4'(a);
        b_in     = 4'(b);
        in_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        apply(5, 3, 1'b1);
        apply(7, 7, 1'b1);
        check("R7 ext prod", int'(prod_ext), 0);
        check("R7 ext valid", int'(vld_ext), 0);
        check("R7 clip prod", int'(prod_clp), 0);
        check("R7 clip valid", int'(vld_clp), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 1'b1);
                check("R1 ext sweep", sval(prod_ext), ref_prod(a, b, 1'b0));
                check("R3 clip sweep", sval(prod_clp), ref_prod(a, b, 1'b1));
            end
        end
        check("R6 valid after sweep", int'(vld_ext), 1);
    endtask

    task automatic t_zero();
        apply(11, 0, 1'b1);   // -5 * 0
        check("R4 ext -5*0", int'(prod_ext), 0);
        check("R4 clip -5*0", int'(prod_clp), 0);
        apply(0, 8, 1'b1);    // 0 * -8
        check("R4 ext 0*-8", int'(prod_ext), 0);
        check("R4 clip 0*-8", int'(prod_clp), 0);
    endtask

    task automatic t_sign();
        apply(13, 5, 1'b1);   // -3 * 5
        check("R5 sign neg", int'(prod_ext[7]), 1);
        check("R5 value", sval(prod_ext), -15);
        apply(13, 11, 1'b1);  // -3 * -5
        check("R5 sign pos", int'(prod_ext[7]), 0);
        apply(7, 15, 1'b1);   // 7 * -1
        check("R5 clip sign", int'(prod_clp[7]), 1);
    endtask

    task automatic t_extreme();
        apply(8, 1, 1'b1);
        check("R2 ext -8*1", int'(prod_ext), 8'hF8);
        check("R3 clip -8*1", sval(prod_clp), -7);
        apply(8, 8, 1'b1);
        check("R8 ext -8*-8", sval(prod_ext), 64);
        check("R8 clip -8*-8", sval(prod_clp), 49);
        apply(8, 7, 1'b1);
        check("R8 ext -8*7", sval(prod_ext), -56);
        check("R8 clip -8*7", sval(prod_clp), -49);
    endtask

    task automatic t_hold();
        apply(3, 3, 1'b1);
        check("R6 load", sval(prod_ext), 9);
        check("R6 valid high", int'(vld_ext), 1);
        apply(14, 5, 1'b0);   // -2 * 5 without valid
        check("R6 hold ext", sval(prod_ext), 9);
        check("R6 hold clip", sval(prod_clp), 9);
        check("R6 valid low", int'(vld_ext), 0);
        apply(14, 5, 1'b1);
        check("R6 reload", sval(prod_ext), -10);
        check("R6 valid back", int'(vld_clp), 1);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_zero();
        t_sign();
        t_extreme();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule